// File: doc/BRIEF.md
# Dual-Clock Frequency Calibration Counter

This block compares the frequency of two unrelated clocks. Software programs a window length, counted in cycles of a reference clock (the "down" clock), and then issues a start command. Logic in the down-clock domain counts out the window. For the same span of time, logic in the clock-under-test domain (the "up" clock) counts its own edges. When the window closes, that count is published to the register side as the result. The busy status then drops, or stays high in continuous mode, and a ready interrupt flag rises.

The window length and the result share one register address. A write sets the window length, and a read returns the last completed result. In continuous mode each window starts straight after the previous one ends, so the result is refreshed on every window and can be read at any time. A stop command aborts a measurement. Commands and events cross between the register clock, the down clock and the up clock through toggle-based pulse synchronizers. The running level crosses through a two-flop synchronizer.

Register map (3-bit address, 32-bit data): 0 count (write window length / read result), 1 control (bit 0 continuous), 2 command (bit 0 start, bit 1 stop, write-only), 3 status (bit 0 busy), 4 flags (bit 0 ready), 5 flag-set, 6 flag-clear, 7 flag-enable. Addresses 2, 5 and 6 read as zero.

Top module: `clk_meas_cal`

## Requirements
- R1: After reset every register address reads 0, busy (status bit 0) is 0 and `irq` is 0.
- R2: A one-shot measurement with window length P (low CNT_W bits written to address 0; P = 0 is treated as 1) returns the number of up-clock cycles in P down-clock cycles, within two counts of P * T_down / T_up, on reads of address 0.
- R3: The up-count saturates at 2^CNT_W - 1 and never wraps.
- R4: Writing command bit 0 (start) sets busy in the next register-clock cycle. In one-shot mode busy clears when the result is published, and the ready flag (flags bit 0) is set in the same cycle.
- R5: With control bit 0 set, windows repeat back to back. Busy stays 1, and every window end sets the ready flag again and refreshes the result.
- R6: Writing command bit 1 (stop) clears busy in the next cycle. After that, no ready flag and no result update come from the aborted window. When start and stop are written together, stop wins.
- R7: A start issued while busy restarts the window from the full programmed length.
- R8: Writing 1s to address 5 sets the matching flags and writing 1s to address 6 clears them. A hardware ready event in the same cycle as a clear leaves the flag set.
- R9: `irq` is high exactly when some flag is set and its bit in address 7 is set.
- R10: The result changes only at window completion, all bits at once. Writing address 0 does not change what it reads back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-side clock |
| rst | input | 1 | Synchronous active-high reset, register domain |
| dn_clk | input | 1 | Reference clock that times the window |
| dn_rst | input | 1 | Synchronous active-high reset, reference domain |
| up_clk | input | 1 | Clock under test |
| up_rst | input | 1 | Synchronous active-high reset, clock-under-test domain |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps window lengths from the zero case up to a few hundred. It compares each result with the arithmetic ratio of the two clock periods, so an off-by-one window or a dropped count shows up as a drift outside the tolerance. With a 10-bit counter, a long window must read exactly the maximum; a counter that wraps would return a small value instead. A restart midway through a long window must delay completion past the moment the first window would have ended, which catches a design that keeps the old remaining count. Continuous operation must keep busy high and re-raise ready. A stop, alone or combined with start, must leave busy low and freeze both the flag and the result, which exposes any window event that leaks through after an abort.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 3;
    localparam int FLAG_W        = 1;
    localparam int CTRL_CONT_BIT = 0;
    localparam int CMD_START_BIT = 0;
    localparam int CMD_STOP_BIT  = 1;
    localparam int STAT_BUSY_BIT = 0;
    localparam int FLAG_RDY_BIT  = 0;

    typedef enum logic [ADDR_W-1:0] {
        A_COUNT  = 3'd0,
        A_CTRL   = 3'd1,
        A_CMD    = 3'd2,
        A_STATUS = 3'd3,
        A_FLAGS  = 3'd4,
        A_FSET   = 3'd5,
        A_FCLR   = 3'd6,
        A_FEN    = 3'd7
    } cal_addr_e;

    // Command request decoded from a write; stop has priority over start.
    typedef struct packed {
        logic start;
        logic stop;
    } cal_cmd_t;

    // Signals leaving the reference-clock domain toward the up domain.
    typedef struct packed {
        logic run;
        logic start_tgl;
        logic end_tgl;
    } win_sig_t;

    function automatic cal_cmd_t decode_cmd(input logic [DATA_W-1:0] w);
        cal_cmd_t c;
        c.stop  = w[CMD_STOP_BIT];
        c.start = w[CMD_START_BIT] & ~w[CMD_STOP_BIT];
        return c;
    endfunction
endpackage

// File: rtl/cal_bit_sync.sv
`timescale 1ns/1ps
module cal_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk) begin
        if (rst) ff <= '0;
        else     ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/cal_tgl_sync.sv
`timescale 1ns/1ps
module cal_tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl,
    output logic pulse
);
    logic tgl_s;
    logic tgl_d;

    cal_bit_sync #(.STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (tgl),
        .q   (tgl_s)
    );

    always_ff @(posedge clk) begin
        if (rst) tgl_d <= 1'b0;
        else     tgl_d <= tgl_s;
    end

    assign pulse = tgl_s ^ tgl_d;
endmodule

// File: rtl/cal_win_ctr.sv
`timescale 1ns/1ps
module cal_win_ctr
    import cal_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic             dn_clk,
    input  logic             dn_rst,
    input  logic             start_tgl,
    input  logic             stop_tgl,
    input  logic             cont,
    input  logic [CNT_W-1:0] period,
    output win_sig_t         win
);
    logic             start_p;
    logic             stop_p;
    logic             cont_s;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] load_val;
    win_sig_t         win_q;

    cal_tgl_sync #(.STAGES(SYNC_STAGES)) u_start (
        .clk(dn_clk), .rst(dn_rst), .tgl(start_tgl), .pulse(start_p));
    cal_tgl_sync #(.STAGES(SYNC_STAGES)) u_stop (
        .clk(dn_clk), .rst(dn_rst), .tgl(stop_tgl), .pulse(stop_p));
    cal_bit_sync #(.STAGES(SYNC_STAGES)) u_cont (
        .clk(dn_clk), .rst(dn_rst), .d(cont), .q(cont_s));

    // Period is quasi-static: software holds it while the start crosses.
    always_comb begin
        load_val = (period == '0) ? CNT_W'(1) : period;
    end

    always_ff @(posedge dn_clk) begin
        if (dn_rst) begin
            win_q  <= '0;
            remain <= '0;
        end else if (stop_p) begin
            win_q.run <= 1'b0;
        end else if (start_p) begin
            win_q.run       <= 1'b1;
            win_q.start_tgl <= ~win_q.start_tgl;
            remain          <= load_val;
        end else if (win_q.run) begin
            if (remain == CNT_W'(1)) begin
                win_q.end_tgl <= ~win_q.end_tgl;
                if (cont_s) begin
                    win_q.start_tgl <= ~win_q.start_tgl;
                    remain          <= load_val;
                end else begin
                    win_q.run <= 1'b0;
                end
            end else begin
                remain <= remain - CNT_W'(1);
            end
        end
    end

    assign win = win_q;

    // R2: a running window always has cycles left to count
    p_run_remaining_r2: assert property (@(posedge dn_clk) disable iff (dn_rst)
        win_q.run |-> (remain != '0));
    // R6: stop halts the window
    p_stop_halts_r6: assert property (@(posedge dn_clk) disable iff (dn_rst)
        stop_p |=> !win_q.run);
    // R7: a start reloads the full programmed length
    p_restart_full_r7: assert property (@(posedge dn_clk) disable iff (dn_rst)
        (start_p && !stop_p) |=> (win_q.run && remain == $past(load_val)));
endmodule

// File: rtl/cal_evt_ctr.sv
`timescale 1ns/1ps
module cal_evt_ctr
    import cal_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic             up_clk,
    input  logic             up_rst,
    input  win_sig_t         win,
    output logic [CNT_W-1:0] res_hold,
    output logic             pub_tgl
);
    localparam logic [CNT_W-1:0] SAT_MAX = '1;

    logic             run_s;
    logic             start_e;
    logic             end_e;
    logic [CNT_W-1:0] cnt;

    cal_bit_sync #(.STAGES(SYNC_STAGES)) u_run (
        .clk(up_clk), .rst(up_rst), .d(win.run), .q(run_s));
    cal_tgl_sync #(.STAGES(SYNC_STAGES)) u_st (
        .clk(up_clk), .rst(up_rst), .tgl(win.start_tgl), .pulse(start_e));
    cal_tgl_sync #(.STAGES(SYNC_STAGES)) u_en (
        .clk(up_clk), .rst(up_rst), .tgl(win.end_tgl), .pulse(end_e));

    always_ff @(posedge up_clk) begin
        if (up_rst) begin
            cnt      <= '0;
            res_hold <= '0;
            pub_tgl  <= 1'b0;
        end else begin
            if (end_e) begin
                res_hold <= cnt;
                pub_tgl  <= ~pub_tgl;
            end
            if (start_e)
                cnt <= '0;
            else if (run_s && !end_e && cnt != SAT_MAX)
                cnt <= cnt + CNT_W'(1);
        end
    end

    // R3: outside a window start the count never decreases (no wrap)
    p_no_wrap_r3: assert property (@(posedge up_clk) disable iff (up_rst)
        !start_e |=> (cnt >= $past(cnt)));
    // R10: the held result only moves at a window end
    p_hold_stable_r10: assert property (@(posedge up_clk) disable iff (up_rst)
        !end_e |=> $stable(res_hold));
endmodule

// File: rtl/clk_meas_cal.sv
`timescale 1ns/1ps
module clk_meas_cal
    import cal_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dn_clk,
    input  logic              dn_rst,
    input  logic              up_clk,
    input  logic              up_rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [CNT_W-1:0]  period_q;
    logic [CNT_W-1:0]  result_q;
    logic [CNT_W-1:0]  res_hold;
    logic              cont_q;
    logic              busy_q;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] flags_n;
    logic [FLAG_W-1:0] fen_q;
    logic              start_tgl;
    logic              stop_tgl;
    logic              pub_tgl;
    logic              done_p;
    logic              done_acc;
    logic              wdata_unused;
    cal_cmd_t          cmd;
    win_sig_t          win;

    assign wdata_unused = ^reg_wdata;

    cal_win_ctr #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_win (
        .dn_clk    (dn_clk),
        .dn_rst    (dn_rst),
        .start_tgl (start_tgl),
        .stop_tgl  (stop_tgl),
        .cont      (cont_q),
        .period    (period_q),
        .win       (win)
    );

    cal_evt_ctr #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_evt (
        .up_clk   (up_clk),
        .up_rst   (up_rst),
        .win      (win),
        .res_hold (res_hold),
        .pub_tgl  (pub_tgl)
    );

    cal_tgl_sync #(.STAGES(SYNC_STAGES)) u_done (
        .clk(clk), .rst(rst), .tgl(pub_tgl), .pulse(done_p));

    always_comb begin
        cmd = '0;
        if (reg_we && reg_addr == A_CMD) cmd = decode_cmd(reg_wdata);
    end

    // A published window counts only while a measurement is owned.
    assign done_acc = done_p && busy_q;

    always_comb begin
        flags_n = flags_q;
        if (reg_we && reg_addr == A_FCLR) flags_n = flags_n & ~reg_wdata[FLAG_W-1:0];
        if (reg_we && reg_addr == A_FSET) flags_n = flags_n | reg_wdata[FLAG_W-1:0];
        if (done_acc) flags_n[FLAG_RDY_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q  <= '0;
            result_q  <= '0;
            cont_q    <= 1'b0;
            busy_q    <= 1'b0;
            flags_q   <= '0;
            fen_q     <= '0;
            start_tgl <= 1'b0;
            stop_tgl  <= 1'b0;
        end else begin
            if (reg_we && reg_addr == A_COUNT) period_q <= reg_wdata[CNT_W-1:0];
            if (reg_we && reg_addr == A_CTRL)  cont_q   <= reg_wdata[CTRL_CONT_BIT];
            if (reg_we && reg_addr == A_FEN)   fen_q    <= reg_wdata[FLAG_W-1:0];
            if (done_acc) result_q <= res_hold;
            flags_q <= flags_n;
            if (cmd.stop) begin
                busy_q   <= 1'b0;
                stop_tgl <= ~stop_tgl;
            end else if (cmd.start) begin
                busy_q    <= 1'b1;
                start_tgl <= ~start_tgl;
            end else if (done_acc && !cont_q) begin
                busy_q <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (cal_addr_e'(reg_addr))
            A_COUNT:  reg_rdata[CNT_W-1:0]      = result_q;
            A_CTRL:   reg_rdata[CTRL_CONT_BIT]  = cont_q;
            A_STATUS: reg_rdata[STAT_BUSY_BIT]  = busy_q;
            A_FLAGS:  reg_rdata[FLAG_W-1:0]     = flags_q;
            A_FEN:    reg_rdata[FLAG_W-1:0]     = fen_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |(flags_q & fen_q);

    // R4: start raises busy
    p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_CMD && reg_wdata[CMD_START_BIT] && !reg_wdata[CMD_STOP_BIT])
        |=> busy_q);
    // R4: busy only drops on a published window or a stop
    p_busy_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> $past(done_p || (reg_we && reg_addr == A_CMD && reg_wdata[CMD_STOP_BIT])));
    // R5: continuous mode keeps busy across a window end
    p_cont_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cont_q && done_p && !(reg_we && reg_addr == A_CMD)) |=> busy_q);
    // R6: stop clears busy
    p_stop_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_CMD && reg_wdata[CMD_STOP_BIT]) |=> !busy_q);
    // R8: a hardware ready event wins over a clear in the same cycle
    p_hw_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        done_acc |=> flags_q[FLAG_RDY_BIT]);
    // R8: a clear with no event lowers the flag
    p_sw_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_FCLR && reg_wdata[FLAG_RDY_BIT] && !done_acc)
        |=> !flags_q[FLAG_RDY_BIT]);
    // R10: the visible result only changes on an accepted window end
    p_result_atomic_r10: assert property (@(posedge clk) disable iff (rst)
        !done_acc |=> $stable(result_q));
endmodule

// File: tb/clk_meas_cal_bench.sv
`timescale 1ns/1ps
module clk_meas_cal_bench;
    localparam int CW   = 10;
    localparam int MAXV = (1 << CW) - 1;
    localparam int TDN  = 30;
    localparam int TUP  = 7;

    logic        clk = 0, dn_clk = 0, up_clk = 0;
    logic        rst = 1, dn_rst = 1, up_rst = 1;
    logic        reg_we = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10  clk    = ~clk;
    always #15  dn_clk = ~dn_clk;
    always #3.5 up_clk = ~up_clk;

    clk_meas_cal #(.CNT_W(CW), .SYNC_STAGES(2)) u_clk_meas_cal (
        .clk(clk), .rst(rst), .dn_clk(dn_clk), .dn_rst(dn_rst),
        .up_clk(up_clk), .up_rst(up_rst), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0; reg_wdata = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_bit(input logic [2:0] a, input logic val, output bit ok);
        logic [31:0] d;
        ok = 0;
        for (int i = 0; i < 6000; i++) begin
            rd(a, d);
            if (d[0] == val) begin ok = 1; break; end
        end
    endtask

    task automatic one_shot(input int n, input int tol, input string req);
        logic [31:0] d;
        bit ok;
        int neff, expv, diff;
        neff = (n == 0) ? 1 : n;
        expv = (neff * TDN) / TUP;
        if (expv > MAXV) expv = MAXV;
        wr(3'd0, n);
        wr(3'd6, 1);
        wr(3'd2, 1);
        rd(3'd3, d);
        check(d[0] == 1'b1, "R4 busy after start", d[0], 1);
        wait_bit(3'd3, 1'b0, ok);
        check(ok, "R4 busy clears", ok, 1);
        rd(3'd4, d);
        check(d[0] == 1'b1, "R4 ready flag", d[0], 1);
        check(irq == 1'b1, "R9 irq with enable", irq, 1);
        rd(3'd0, d);
        diff = int'(d) - expv;
        if (diff < 0) diff = -diff;
        check(diff <= tol, req, d, expv);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, keep;
        bit ok;
        int plist [12] = '{0, 1, 2, 3, 4, 7, 16, 31, 64, 100, 150, 200};

        repeat (10) @(negedge clk);
        rst = 0; dn_rst = 0; up_rst = 0;
        repeat (4) @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check(d == 0, "R1 register reset", d, 0);
        end
        check(irq == 1'b0, "R1 irq reset", irq, 0);

        // R8 / R9: software set, enable and clear
        wr(3'd5, 1);
        rd(3'd4, d);
        check(d[0] == 1'b1, "R8 flag set", d[0], 1);
        check(irq == 1'b0, "R9 irq masked", irq, 0);
        wr(3'd7, 1);
        check(irq == 1'b1, "R9 irq enabled", irq, 1);
        wr(3'd6, 1);
        rd(3'd4, d);
        check(d[0] == 1'b0, "R8 flag clear", d[0], 0);
        check(irq == 1'b0, "R9 irq after clear", irq, 0);

        // R2: sweep of window lengths
        foreach (plist[i]) one_shot(plist[i], 2, "R2 measured count");

        // R10: writing the window length leaves the result readback alone
        rd(3'd0, keep);
        wr(3'd0, 5);
        rd(3'd0, d);
        check(d == keep, "R10 count write keeps result", d, keep);
        rd(3'd3, d);
        check(d[0] == 1'b0, "R10 write does not start", d[0], 0);

        // R3: saturation
        one_shot(600, 0, "R3 saturated count");

        // R7: restart midway through a long window
        wr(3'd0, 200);
        wr(3'd6, 1);
        wr(3'd2, 1);
        repeat (150) @(negedge clk);
        wr(3'd2, 1);
        repeat (225) @(negedge clk);
        rd(3'd4, d);
        check(d[0] == 1'b0, "R7 no early ready after restart", d[0], 0);
        rd(3'd3, d);
        check(d[0] == 1'b1, "R7 still busy after restart", d[0], 1);
        wait_bit(3'd3, 1'b0, ok);
        check(ok, "R7 restarted window ends", ok, 1);
        rd(3'd0, d);
        check((int'(d) >= (200*TDN)/TUP - 2) && (int'(d) <= (200*TDN)/TUP + 2),
              "R7 full window count", d, (200*TDN)/TUP);

        // R5: continuous mode
        wr(3'd1, 1);
        wr(3'd0, 50);
        wr(3'd6, 1);
        wr(3'd2, 1);
        wait_bit(3'd4, 1'b1, ok);
        check(ok, "R5 first ready", ok, 1);
        wr(3'd6, 1);
        wait_bit(3'd4, 1'b1, ok);
        check(ok, "R5 ready again", ok, 1);
        rd(3'd3, d);
        check(d[0] == 1'b1, "R5 busy stays high", d[0], 1);
        rd(3'd0, d);
        check((int'(d) >= (50*TDN)/TUP - 2) && (int'(d) <= (50*TDN)/TUP + 2),
              "R5 continuous count", d, (50*TDN)/TUP);

        // R6: stop ends continuous operation
        wr(3'd2, 2);
        rd(3'd3, d);
        check(d[0] == 1'b0, "R6 busy after stop", d[0], 0);
        rd(3'd0, keep);
        wr(3'd6, 1);
        repeat (150) @(negedge clk);
        rd(3'd4, d);
        check(d[0] == 1'b0, "R6 no ready after stop", d[0], 0);
        rd(3'd0, d);
        check(d == keep, "R6 result frozen after stop", d, keep);
        wr(3'd1, 0);

        // R6: stop wins over start in the same write
        wr(3'd0, 20);
        wr(3'd2, 3);
        rd(3'd3, d);
        check(d[0] == 1'b0, "R6 stop beats start", d[0], 0);
        repeat (100) @(negedge clk);
        rd(3'd4, d);
        check(d[0] == 1'b0, "R6 no ready from combined write", d[0], 0);

        // R6: abort a one-shot window
        wr(3'd0, 200);
        wr(3'd2, 1);
        repeat (50) @(negedge clk);
        wr(3'd2, 2);
        rd(3'd3, d);
        check(d[0] == 1'b0, "R6 one-shot abort", d[0], 0);
        repeat (400) @(negedge clk);
        rd(3'd4, d);
        check(d[0] == 1'b0, "R6 aborted window silent", d[0], 0);
        rd(3'd2, d);
        check(d == 0, "R1 command reads zero", d, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule